// File: doc/BRIEF.md
# Triggered Collective Descriptor Sequencer

This block sits in a network interface and offloads collective operations such as barrier and broadcast. Software writes a short chain of send descriptors into a local store ahead of time, one chain per virtual port, and then arms that chain. An armed chain does nothing on its own. It runs only when a control packet from the network names it. The packet's payload supplies a replacement address and a replacement virtual-port value. Each descriptor carries two swap bits that decide whether those fields are overwritten as the descriptor leaves the block.

Once triggered, the engine presents the chain's descriptors one at a time on a valid/ready send port, in index order. A chain ends at the first descriptor whose end flag is set, or at the last slot if no end flag is set. Arming is one-shot: accepting a trigger consumes the arm. While one chain is issuing, a single further trigger can wait in a one-entry holding register. Any trigger that cannot be taken is dropped and counted.

The engine has four states. IDLE means no chain is armed. ARMED means at least one chain is armed and nothing is issuing. ISSUE presents descriptors. DONE is a single dead cycle after a chain's final handshake. The transitions are:
- IDLE→ARMED on an arm request.
- IDLE/ARMED→ISSUE on a matching trigger.
- ISSUE→ISSUE while descriptors remain.
- ISSUE→DONE when the final descriptor is accepted.
- DONE→ISSUE if a trigger is held, or if a matching trigger arrives in that cycle.
- DONE→ARMED or DONE→IDLE otherwise, depending on whether any chain is still armed.

Top module: `coll_trig_seq`

## Requirements
- R1: After reset the engine is in IDLE, send_valid is low and drop_count is zero.
- R2: Loading descriptors and arming chains never raises send_valid. send_valid rises only in the cycle after a trigger that names an armed chain, or after DONE when a trigger is held.
- R3: A trigger whose ID is not armed is discarded. It raises drop_count by exactly one and starts no issue. drop_count never changes in a cycle without trig_valid.
- R4: A trigger accepted in IDLE/ARMED raises send_valid in the next cycle. Descriptors then leave in index order starting at index 0, one per cycle in which send_valid and send_ready are both high, and send_seq shows the chain ID.
- R5: Each descriptor holds two swap bits. When the address swap bit is 1, send_addr equals the trigger's trig_addr; when it is 0, send_addr is the stored address. The virtual-port swap bit selects trig_vport or the stored vport for send_vport in the same way. Opcode and destination always pass through unchanged.
- R6: While send_valid is high and send_ready is low, send_valid stays high and all send fields hold their values.
- R7: A chain ends with the handshake of the first descriptor whose end flag is 1, or with index SEQ_DEPTH-1 if no end flag is set; send_last is high on that descriptor. Exactly one DONE cycle with send_valid low follows.
- R8: Accepting a trigger disarms its chain. A second trigger for the same ID without a new arm is dropped (R3).
- R9: A matching trigger that arrives during ISSUE or DONE goes into the holding register if it is empty. The held chain starts after DONE, so exactly one idle cycle separates the two chains. A matching trigger that finds the holding register full is dropped and counted.
- R10: If an arm request and a trigger for the same ID arrive in the same cycle, the trigger sees the chain as not armed and is dropped, while the arm request still takes effect. An arm request also wins over the disarm caused by an accepted trigger in the same cycle.
- R11: drop_count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Write one descriptor into the store |
| ld_vp | input | VP_W | Chain (virtual port) being written |
| ld_idx | input | IDX_W | Slot within the chain |
| ld_op | input | OP_W | Descriptor opcode |
| ld_dest | input | DEST_W | Descriptor destination |
| ld_vport | input | VPORT_W | Stored virtual-port field |
| ld_addr | input | ADDR_W | Stored address field |
| ld_swap_addr | input | 1 | 1: replace address from trigger |
| ld_swap_vport | input | 1 | 1: replace virtual port from trigger |
| ld_last | input | 1 | 1: final descriptor of the chain |
| arm_valid | input | 1 | Arm one chain |
| arm_vp | input | VP_W | Chain to arm |
| trig_valid | input | 1 | Control packet present |
| trig_id | input | VP_W | Chain named by the packet |
| trig_addr | input | ADDR_W | Replacement address |
| trig_vport | input | VPORT_W | Replacement virtual port |
| send_valid | output | 1 | Descriptor presented |
| send_ready | input | 1 | Send side accepts |
| send_seq | output | VP_W | Chain being issued |
| send_op | output | OP_W | Opcode |
| send_dest | output | DEST_W | Destination |
| send_vport | output | VPORT_W | Virtual port after swap |
| send_addr | output | ADDR_W | Address after swap |
| send_last | output | 1 | Final descriptor of the chain |
| drop_count | output | DROP_W | Saturating count of discarded triggers |

## Verification
The assertions check the following on every cycle:
- Stalled descriptors hold still.
- DONE never lasts more than one cycle.
- The holding register is occupied only during ISSUE or DONE.
- Every rise of send_valid is preceded by a trigger or a held entry.
- drop_count moves only on a trigger.
- A chain is only ever disarmed while it is armed.

Only the bench's scenarios can show the rest: the values of patched fields, the ordering and length of each chain, one-shot arming, the one-cycle gap before a held chain, same-cycle arm/trigger priority, and saturation of the drop counter.

// File: rtl/ctds_pkg.sv
`timescale 1ns/1ps
package ctds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ctds_desc_store.sv
`timescale 1ns/1ps
module ctds_desc_store #(
    parameter int NUM_VP    = 4,
    parameter int SEQ_DEPTH = 4,
    parameter int OP_W      = 4,
    parameter int DEST_W    = 8,
    parameter int VPORT_W   = 4,
    parameter int ADDR_W    = 16,
    localparam int VP_W     = $clog2(NUM_VP),
    localparam int IDX_W    = $clog2(SEQ_DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [VP_W-1:0]    wr_vp,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [OP_W-1:0]    wr_op,
    input  logic [DEST_W-1:0]  wr_dest,
    input  logic [VPORT_W-1:0] wr_vport,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_swap_addr,
    input  logic               wr_swap_vport,
    input  logic               wr_last,
    input  logic [VP_W-1:0]    rd_vp,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [OP_W-1:0]    rd_op,
    output logic [DEST_W-1:0]  rd_dest,
    output logic [VPORT_W-1:0] rd_vport,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_swap_addr,
    output logic               rd_swap_vport,
    output logic               rd_last
);
    localparam int ENTRIES = NUM_VP * SEQ_DEPTH;
    localparam int SLOT_W  = VP_W + IDX_W;
    localparam int WORD_W  = OP_W + DEST_W + VPORT_W + ADDR_W + 3;

    logic [WORD_W-1:0] store_q [ENTRIES];
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic [WORD_W-1:0] rd_word;

    assign wr_slot = {wr_vp, wr_idx};
    assign rd_slot = {rd_vp, rd_idx};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_slot] <= {wr_op, wr_dest, wr_vport, wr_addr,
                                 wr_swap_addr, wr_swap_vport, wr_last};
        end
    end

    assign rd_word = store_q[rd_slot];
    assign {rd_op, rd_dest, rd_vport, rd_addr,
            rd_swap_addr, rd_swap_vport, rd_last} = rd_word;
endmodule

// File: rtl/ctds_arm_table.sv
`timescale 1ns/1ps
module ctds_arm_table #(
    parameter int NUM_VP = 4,
    localparam int VP_W  = $clog2(NUM_VP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_valid,
    input  logic [VP_W-1:0] set_vp,
    input  logic            clr_valid,
    input  logic [VP_W-1:0] clr_vp,
    input  logic [VP_W-1:0] query_vp,
    output logic            query_hit,
    output logic            any_armed
);
    logic [NUM_VP-1:0] armed_q;

    for (genvar g = 0; g < NUM_VP; g++) begin : g_arm
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q[g] <= 1'b0;
            end else if (set_valid && set_vp == VP_W'(g)) begin
                armed_q[g] <= 1'b1;
            end else if (clr_valid && clr_vp == VP_W'(g)) begin
                armed_q[g] <= 1'b0;
            end
        end
    end

    assign query_hit = armed_q[query_vp];
    assign any_armed = |armed_q;

    // R8
    clr_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> armed_q[clr_vp]);
endmodule

// File: rtl/ctds_field_patch.sv
`timescale 1ns/1ps
module ctds_field_patch #(
    parameter int VPORT_W = 4,
    parameter int ADDR_W  = 16
) (
    input  logic [VPORT_W-1:0] base_vport,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               swap_vport,
    input  logic               swap_addr,
    input  logic [VPORT_W-1:0] new_vport,
    input  logic [ADDR_W-1:0]  new_addr,
    output logic [VPORT_W-1:0] out_vport,
    output logic [ADDR_W-1:0]  out_addr
);
    always_comb begin
        out_vport = swap_vport ? new_vport : base_vport;
        out_addr  = swap_addr  ? new_addr  : base_addr;
    end
endmodule

// File: rtl/coll_trig_seq.sv
`timescale 1ns/1ps
module coll_trig_seq
    import ctds_pkg::*;
#(
    parameter int NUM_VP    = 4,
    parameter int SEQ_DEPTH = 4,
    parameter int OP_W      = 4,
    parameter int DEST_W    = 8,
    parameter int VPORT_W   = 4,
    parameter int ADDR_W    = 16,
    parameter int DROP_W    = 8,
    localparam int VP_W     = $clog2(NUM_VP),
    localparam int IDX_W    = $clog2(SEQ_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [VP_W-1:0]    ld_vp,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [OP_W-1:0]    ld_op,
    input  logic [DEST_W-1:0]  ld_dest,
    input  logic [VPORT_W-1:0] ld_vport,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic               ld_swap_addr,
    input  logic               ld_swap_vport,
    input  logic               ld_last,
    input  logic               arm_valid,
    input  logic [VP_W-1:0]    arm_vp,
    input  logic               trig_valid,
    input  logic [VP_W-1:0]    trig_id,
    input  logic [ADDR_W-1:0]  trig_addr,
    input  logic [VPORT_W-1:0] trig_vport,
    output logic               send_valid,
    input  logic               send_ready,
    output logic [VP_W-1:0]    send_seq,
    output logic [OP_W-1:0]    send_op,
    output logic [DEST_W-1:0]  send_dest,
    output logic [VPORT_W-1:0] send_vport,
    output logic [ADDR_W-1:0]  send_addr,
    output logic               send_last,
    output logic [DROP_W-1:0]  drop_count
);
    localparam logic [IDX_W-1:0]  IDX_MAX  = IDX_W'(SEQ_DEPTH - 1);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    seq_state_t         state_q, state_d;
    logic [VP_W-1:0]    cur_vp_q;
    logic [IDX_W-1:0]   cur_idx_q;
    logic [ADDR_W-1:0]  cur_addr_q;
    logic [VPORT_W-1:0] cur_vport_q;
    logic               hold_valid_q;
    logic [VP_W-1:0]    hold_vp_q;
    logic [ADDR_W-1:0]  hold_addr_q;
    logic [VPORT_W-1:0] hold_vport_q;
    logic [DROP_W-1:0]  drop_q;

    logic               arm_hit, any_armed;
    logic               start_trig, start_hold, to_hold, drop_now;
    logic               take, chain_end;
    logic [VPORT_W-1:0] st_vport;
    logic [ADDR_W-1:0]  st_addr;
    logic               st_swap_addr, st_swap_vport, st_last;

    ctds_desc_store #(
        .NUM_VP(NUM_VP), .SEQ_DEPTH(SEQ_DEPTH), .OP_W(OP_W),
        .DEST_W(DEST_W), .VPORT_W(VPORT_W), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .wr_en(ld_valid), .wr_vp(ld_vp), .wr_idx(ld_idx),
        .wr_op(ld_op), .wr_dest(ld_dest), .wr_vport(ld_vport),
        .wr_addr(ld_addr), .wr_swap_addr(ld_swap_addr),
        .wr_swap_vport(ld_swap_vport), .wr_last(ld_last),
        .rd_vp(cur_vp_q), .rd_idx(cur_idx_q),
        .rd_op(send_op), .rd_dest(send_dest), .rd_vport(st_vport),
        .rd_addr(st_addr), .rd_swap_addr(st_swap_addr),
        .rd_swap_vport(st_swap_vport), .rd_last(st_last)
    );

    ctds_arm_table #(.NUM_VP(NUM_VP)) u_arm (
        .clk(clk), .rst_n(rst_n),
        .set_valid(arm_valid), .set_vp(arm_vp),
        .clr_valid(start_trig | to_hold), .clr_vp(trig_id),
        .query_vp(trig_id), .query_hit(arm_hit), .any_armed(any_armed)
    );

    ctds_field_patch #(.VPORT_W(VPORT_W), .ADDR_W(ADDR_W)) u_patch (
        .base_vport(st_vport), .base_addr(st_addr),
        .swap_vport(st_swap_vport), .swap_addr(st_swap_addr),
        .new_vport(cur_vport_q), .new_addr(cur_addr_q),
        .out_vport(send_vport), .out_addr(send_addr)
    );

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cur_vp_q     <= '0;
            cur_idx_q    <= '0;
            cur_addr_q   <= '0;
            cur_vport_q  <= '0;
            hold_valid_q <= 1'b0;
            hold_vp_q    <= '0;
            hold_addr_q  <= '0;
            hold_vport_q <= '0;
            drop_q       <= '0;
        end else begin
            state_q <= state_d;
            if (start_trig) begin
                cur_vp_q    <= trig_id;
                cur_addr_q  <= trig_addr;
                cur_vport_q <= trig_vport;
                cur_idx_q   <= '0;
            end else if (start_hold) begin
                cur_vp_q    <= hold_vp_q;
                cur_addr_q  <= hold_addr_q;
                cur_vport_q <= hold_vport_q;
                cur_idx_q   <= '0;
            end else if (take && !chain_end) begin
                cur_idx_q <= cur_idx_q + 1'b1;
            end
            if (to_hold) begin
                hold_valid_q <= 1'b1;
                hold_vp_q    <= trig_id;
                hold_addr_q  <= trig_addr;
                hold_vport_q <= trig_vport;
            end else if (start_hold) begin
                hold_valid_q <= 1'b0;
            end
            if (drop_now && drop_q != DROP_MAX) begin
                drop_q <= drop_q + 1'b1;
            end
        end
    end

    // Next state and decisions
    always_comb begin
        state_d    = state_q;
        start_trig = 1'b0;
        start_hold = 1'b0;
        to_hold    = 1'b0;
        drop_now   = 1'b0;
        take       = (state_q == ST_ISSUE) && send_ready;
        chain_end  = take && (st_last || cur_idx_q == IDX_MAX);
        unique case (state_q)
            ST_IDLE, ST_ARMED: begin
                if (trig_valid && arm_hit) begin
                    start_trig = 1'b1;
                    state_d    = ST_ISSUE;
                end else begin
                    drop_now = trig_valid;
                    state_d  = (any_armed || arm_valid) ? ST_ARMED : ST_IDLE;
                end
            end
            ST_ISSUE: begin
                if (trig_valid && arm_hit && !hold_valid_q) to_hold = 1'b1;
                else drop_now = trig_valid;
                if (chain_end) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (hold_valid_q) begin
                    start_hold = 1'b1;
                    state_d    = ST_ISSUE;
                    if (trig_valid && arm_hit) to_hold = 1'b1;
                    else drop_now = trig_valid;
                end else if (trig_valid && arm_hit) begin
                    start_trig = 1'b1;
                    state_d    = ST_ISSUE;
                end else begin
                    drop_now = trig_valid;
                    state_d  = (any_armed || arm_valid) ? ST_ARMED : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        send_valid = (state_q == ST_ISSUE);
        send_seq   = cur_vp_q;
        send_last  = st_last || (cur_idx_q == IDX_MAX);
        drop_count = drop_q;
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_valid && !send_ready) |=> (send_valid && $stable(send_addr)
            && $stable(send_vport) && $stable(send_op) && $stable(send_dest)
            && $stable(send_seq)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q != ST_DONE));

    // R9
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid_q |-> (state_q == ST_ISSUE || state_q == ST_DONE));

    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_valid) |-> $past(trig_valid || hold_valid_q));

    // R3
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_valid |=> $stable(drop_count));
endmodule

// File: tb/coll_trig_seq_bench.sv
`timescale 1ns/1ps
module coll_trig_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 0; logic [1:0] ld_vp = 0; logic [1:0] ld_idx = 0;
    logic [3:0] ld_op = 0; logic [7:0] ld_dest = 0; logic [3:0] ld_vport = 0;
    logic [15:0] ld_addr = 0; logic ld_swap_addr = 0, ld_swap_vport = 0, ld_last = 0;
    logic arm_valid = 0; logic [1:0] arm_vp = 0;
    logic trig_valid = 0; logic [1:0] trig_id = 0;
    logic [15:0] trig_addr = 0; logic [3:0] trig_vport = 0;
    logic send_valid, send_ready = 0, send_last;
    logic [1:0] send_seq; logic [3:0] send_op; logic [7:0] send_dest;
    logic [3:0] send_vport; logic [15:0] send_addr; logic [7:0] drop_count;

    int checks = 0, errors = 0, cyc = 0, ready_mode = 0, rec_n = 0, exp_drop = 0;
    logic [3:0] r_op [64]; logic [7:0] r_dest [64]; logic [3:0] r_vport [64];
    logic [15:0] r_addr [64]; logic [1:0] r_seq [64]; logic r_last [64]; int r_cyc [64];

    coll_trig_seq u_coll_trig_seq (.*);

    always #4 clk = ~clk;

    initial forever begin @(posedge clk); cyc++; end
    initial forever begin
        @(posedge clk); #1;
        send_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: record handshakes, verify stall stability (R6)
    initial begin
        bit stalled = 0;
        logic [15:0] p_addr; logic [3:0] p_vport; logic [7:0] p_dest;
        forever begin
            @(negedge clk);
            if (rst_n && stalled)
                chk(send_valid && send_addr == p_addr && send_vport == p_vport
                    && send_dest == p_dest, "R6", "stall hold", send_addr, p_addr);
            stalled = rst_n && send_valid && !send_ready;
            p_addr = send_addr; p_vport = send_vport; p_dest = send_dest;
            if (rst_n && send_valid && send_ready && rec_n < 64) begin
                r_op[rec_n] = send_op; r_dest[rec_n] = send_dest;
                r_vport[rec_n] = send_vport; r_addr[rec_n] = send_addr;
                r_seq[rec_n] = send_seq; r_last[rec_n] = send_last;
                r_cyc[rec_n] = cyc; rec_n++;
            end
        end
    end

    function automatic int seq_len(int v); return v + 1; endfunction
    function automatic logic [3:0]  e_op(int v, int i);   return 4'((v*4+i)%16); endfunction
    function automatic logic [7:0]  e_dest(int v, int i); return 8'(v*16+i+1); endfunction
    function automatic logic [3:0]  e_vp(int v, int i);   return 4'((v*3+i)%16); endfunction
    function automatic logic [15:0] e_addr(int v, int i); return 16'(256*(v+1)+i*4); endfunction
    function automatic bit e_sa(int i); return (i % 2) == 1; endfunction
    function automatic bit e_sv(int v, int i); return ((v+i) % 3) == 0; endfunction

    task automatic step(); @(posedge clk); #1; endtask

    task automatic load_all();
        for (int v = 0; v < 4; v++)
            for (int i = 0; i < 4; i++) begin
                ld_valid = 1; ld_vp = 2'(v); ld_idx = 2'(i);
                ld_op = e_op(v,i); ld_dest = e_dest(v,i); ld_vport = e_vp(v,i);
                ld_addr = e_addr(v,i); ld_swap_addr = e_sa(i); ld_swap_vport = e_sv(v,i);
                ld_last = (i == v) && (v != 3);
                step();
            end
        ld_valid = 0;
    endtask

    task automatic arm(int v);
        arm_valid = 1; arm_vp = 2'(v); step(); arm_valid = 0;
    endtask

    task automatic fire(int v, logic [15:0] a, logic [3:0] p);
        trig_valid = 1; trig_id = 2'(v); trig_addr = a; trig_vport = p;
        step(); trig_valid = 0;
    endtask

    task automatic verify(int base, int v, logic [15:0] a, logic [3:0] p, string req);
        for (int i = 0; i < seq_len(v); i++) begin
            int k = base + i;
            logic [15:0] xa = e_sa(i) ? a : e_addr(v,i);
            logic [3:0]  xp = e_sv(v,i) ? p : e_vp(v,i);
            chk(r_seq[k] == 2'(v) && r_op[k] == e_op(v,i) && r_dest[k] == e_dest(v,i),
                req, "seq/op/dest", r_dest[k], e_dest(v,i));
            chk(r_addr[k] == xa, "R5", "addr", r_addr[k], xa);
            chk(r_vport[k] == xp, "R5", "vport", r_vport[k], xp);
            chk(r_last[k] == (i == seq_len(v)-1), "R7", "last flag", r_last[k], i == seq_len(v)-1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk(!send_valid, "R1", "valid after reset", send_valid, 0);
        chk(drop_count == 0, "R1", "drop after reset", drop_count, 0);
        @(posedge clk); #1;

        // R2: load and arm, no issue without trigger
        load_all();
        for (int v = 0; v < 4; v++) arm(v);
        repeat (10) step();
        chk(rec_n == 0 && !send_valid, "R2", "no issue before trigger", rec_n, 0);
        chk(drop_count == 0, "R2", "no drops", drop_count, 0);

        // R4 R5 R7: each chain, ready held high
        for (int v = 0; v < 4; v++) begin
            logic [15:0] a = 16'(16'hA000 + v*16'h111);
            logic [3:0]  p = 4'((9+v)%16);
            base = rec_n;
            fire(v, a, p);
            @(negedge clk);
            chk(send_valid, "R4", "valid one cycle after trigger", send_valid, 1);
            repeat (8) step();
            chk(rec_n - base == seq_len(v), "R7", "chain length", rec_n - base, seq_len(v));
            verify(base, v, a, p, "R4");
        end

        // R8: re-trigger without re-arm
        base = rec_n;
        fire(0, 16'h1234, 4'h5); exp_drop++;
        repeat (4) step();
        chk(rec_n == base, "R8", "one-shot arm", rec_n - base, 0);
        chk(drop_count == 8'(exp_drop), "R3", "drop count", drop_count, exp_drop);

        // R6: stalls with sparse ready
        ready_mode = 1; arm(3); base = rec_n;
        fire(3, 16'hBEEF, 4'hC);
        repeat (20) step();
        chk(rec_n - base == 4, "R6", "count under stall", rec_n - base, 4);
        verify(base, 3, 16'hBEEF, 4'hC, "R6");
        ready_mode = 0; step();

        // R9: hold register, full-hold drop, one-cycle gap
        arm(3); arm(2); base = rec_n;
        fire(3, 16'h3333, 4'h3);
        fire(2, 16'h2222, 4'h2);
        arm(0);
        fire(0, 16'h0F0F, 4'h1); exp_drop++;
        repeat (12) step();
        chk(rec_n - base == 7, "R9", "two chains issued", rec_n - base, 7);
        verify(base, 3, 16'h3333, 4'h3, "R9");
        verify(base + 4, 2, 16'h2222, 4'h2, "R9");
        chk(r_cyc[base+4] - r_cyc[base+3] == 2, "R9", "gap cycles",
            r_cyc[base+4] - r_cyc[base+3], 2);
        chk(drop_count == 8'(exp_drop), "R9", "drop on full hold", drop_count, exp_drop);
        base = rec_n;
        fire(0, 16'h0A0A, 4'h7);
        repeat (4) step();
        chk(rec_n - base == 1, "R9", "dropped chain stays armed", rec_n - base, 1);
        verify(base, 0, 16'h0A0A, 4'h7, "R9");

        // R10: same-cycle arm and trigger
        base = rec_n;
        arm_valid = 1; arm_vp = 2'd1;
        trig_valid = 1; trig_id = 2'd1; trig_addr = 16'h5555; trig_vport = 4'h6;
        step(); arm_valid = 0; trig_valid = 0; exp_drop++;
        repeat (4) step();
        chk(rec_n == base, "R10", "trigger sees old arm", rec_n - base, 0);
        chk(drop_count == 8'(exp_drop), "R10", "drop count", drop_count, exp_drop);
        fire(1, 16'h6666, 4'h8);
        repeat (5) step();
        chk(rec_n - base == 2, "R10", "arm took effect", rec_n - base, 2);
        verify(base, 1, 16'h6666, 4'h8, "R10");

        // R11: saturation
        trig_valid = 1; trig_id = 2'd1;
        repeat (300) step();
        trig_valid = 0; step();
        chk(drop_count == 8'hFF, "R11", "saturated drop count", drop_count, 255);
        chk(!send_valid, "R3", "no issue from unarmed triggers", send_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule